// File: doc/BRIEF.md
# Configuration Request Handshake Controller

This block is a word-addressed register bank. Through it a processor sends single configuration transactions to an external agent, then polls for their completion. Software first loads the outgoing data word and a control word. The control word names a function, a device and a direction. Setting the start bit in that same control word launches the transaction. The block then holds a request line high toward the agent and fires a one-cycle event pulse that can serve as an interrupt. The request line stays high until the agent acknowledges. At acknowledge the block records completion, records a possible error flag and, on reads, captures the word the agent returns.

The same bank also holds three further things: a register that drives eight LEDs, read-only views of eight switches and a board revision input, and a fixed identification word. The bank ignores the two lowest address bits, so all offsets are word offsets. Reads are combinational from the current address. Writes take effect on the next clock edge.

Top module: `cfg_req_ctrl`

## Requirements
- R1: After an asynchronous active-low reset the following are all zero: `req_o`, `start_pulse_o` and `led_o`, and every writable or status register.
- R2: Address bits 1:0 have no effect on reads or writes. For example, offsets 0x0A4 and 0x0A7 select the same register.
- R3: The outgoing data register (0x0A4) and the return data register (0x0A0) can both be read and written. The outgoing register drives `req_data_o`.
- R4: The control register (0x0A8) has this layout: bit 31 is start/busy, bit 30 is direction (1 = write, 0 = read), bits 25:20 are function and bits 11:0 are device. Every other bit reads 0. The stored fields drive `req_write_o`, `req_func_o` and `req_dev_o`.
- R5: A write to the control register with bit 31 set, made while no request is outstanding, does three things. From the next cycle `req_o` is high. `start_pulse_o` is high for exactly that one cycle. Bit 31 of the control register reads 1 until acknowledge.
- R6: The status register (0x0AC) holds complete in bit 0 and error in bit 1. Launching a request clears both. Writes to the status register are ignored.
- R7: When `ack_i` is high during an outstanding request, `req_o` falls in the next cycle, complete becomes 1 and error takes the value of `ack_err_i`.
- R8: At acknowledge of a read request (direction 0), `ack_data_i` is loaded into the return data register. A write request leaves that register unchanged.
- R9: While a request is outstanding, writes to the control register are ignored entirely, including all fields. When no request is outstanding, `ack_i` has no effect.
- R10: Bits 7:0 at 0x004 are read/write and drive `led_o`. Bits 7:0 at 0x00C read `sw_i`. Bits 3:0 at 0x010 read `board_rev_i`.
- R11: Offset 0xFFC reads a constant identification word: implementer 0x41 in bits 31:24, variant in bits 23:20, architecture 0x4 in bits 19:16, part in bits 11:4 and revision in bits 3:0. With the default parameters the word is 0x41140A52. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access valid |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address; bits 1:0 ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address |
| req_o | output | 1 | Request outstanding toward the agent |
| req_write_o | output | 1 | Request direction, 1 = write |
| req_func_o | output | 6 | Function code |
| req_dev_o | output | 12 | Device code |
| req_data_o | output | 32 | Outgoing data word |
| start_pulse_o | output | 1 | One-cycle launch event |
| ack_i | input | 1 | Agent acknowledge |
| ack_err_i | input | 1 | Agent reports failure with acknowledge |
| ack_data_i | input | 32 | Agent return data |
| led_o | output | 8 | LED drive |
| sw_i | input | 8 | Switch levels |
| board_rev_i | input | 4 | Board revision |

## Verification
A busy flag stuck high or stuck low shows on `req_o` in the cycle after the launch or acknowledge that should have changed it. The control register's bit 31 and the status word read back the same fault immediately. Lost or stale request fields show on `req_func_o`/`req_dev_o` in the cycle after an ignored write. A capture on the wrong direction, or from the wrong source, corrupts the return register, and this is visible at the first read after acknowledge. Because the bench compares every output and the addressed read word on every clock, a wrong state is reported at most one cycle after it appears.

// File: rtl/cfg_req_pkg.sv
package cfg_req_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned FUNC_W = 6;
  localparam int unsigned DEV_W  = 12;
  localparam int unsigned LED_W  = 8;
  localparam int unsigned SW_W   = 8;
  localparam int unsigned REV_W  = 4;

  // control word bit positions
  localparam int unsigned CTL_START = 31;
  localparam int unsigned CTL_DIR   = 30;
  localparam int unsigned FUNC_LSB  = 20;
  localparam int unsigned DEV_LSB   = 0;

  // word offsets
  localparam logic [WORD_W-1:0] W_LED  = WORD_W'(12'h004 >> 2);
  localparam logic [WORD_W-1:0] W_SW   = WORD_W'(12'h00C >> 2);
  localparam logic [WORD_W-1:0] W_REV  = WORD_W'(12'h010 >> 2);
  localparam logic [WORD_W-1:0] W_RTN  = WORD_W'(12'h0A0 >> 2);
  localparam logic [WORD_W-1:0] W_OUT  = WORD_W'(12'h0A4 >> 2);
  localparam logic [WORD_W-1:0] W_CTL  = WORD_W'(12'h0A8 >> 2);
  localparam logic [WORD_W-1:0] W_STAT = WORD_W'(12'h0AC >> 2);
  localparam logic [WORD_W-1:0] W_ID   = WORD_W'(12'hFFC >> 2);

  typedef enum logic [3:0] {
    SEL_NONE, SEL_LED, SEL_SW, SEL_REV, SEL_RTN,
    SEL_OUT, SEL_CTL, SEL_STAT, SEL_ID
  } reg_sel_e;

  typedef struct packed {
    logic              wr;
    logic [FUNC_W-1:0] func;
    logic [DEV_W-1:0]  dev;
  } ctl_t;
endpackage

// File: rtl/cfg_reg_decode.sv
module cfg_reg_decode
  import cfg_req_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  logic [WORD_W-1:0] word;
  logic              unused_lsb;

  assign word       = addr_i[ADDR_W-1:2];
  assign unused_lsb = ^addr_i[1:0];

  always_comb begin
    unique case (word)
      W_LED:   sel_o = SEL_LED;
      W_SW:    sel_o = SEL_SW;
      W_REV:   sel_o = SEL_REV;
      W_RTN:   sel_o = SEL_RTN;
      W_OUT:   sel_o = SEL_OUT;
      W_CTL:   sel_o = SEL_CTL;
      W_STAT:  sel_o = SEL_STAT;
      W_ID:    sel_o = SEL_ID;
      default: sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/cfg_plain_regs.sv
module cfg_plain_regs
  import cfg_req_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              led_we_i,
  input  logic              out_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [LED_W-1:0]  led_o,
  output logic [DATA_W-1:0] out_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      led_o <= '0;
      out_o <= '0;
    end else begin
      if (led_we_i) led_o <= wdata_i[LED_W-1:0];
      if (out_we_i) out_o <= wdata_i;
    end
  end
endmodule

// File: rtl/cfg_txn_engine.sv
module cfg_txn_engine
  import cfg_req_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic              rtn_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  input  logic              ack_err_i,
  input  logic [DATA_W-1:0] ack_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              pulse_o,
  output ctl_t              ctl_o,
  output logic [DATA_W-1:0] rtn_o
);
  logic launch, finish, unused_wbits;

  assign launch       = ctl_we_i && !busy_o && wdata_i[CTL_START];
  assign finish       = busy_o && ack_i;
  assign unused_wbits = ^{wdata_i[29:26], wdata_i[19:12]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      pulse_o <= 1'b0;
      ctl_o   <= '0;
      rtn_o   <= '0;
    end else begin
      pulse_o <= launch;
      if (ctl_we_i && !busy_o) begin
        ctl_o.wr   <= wdata_i[CTL_DIR];
        ctl_o.func <= wdata_i[FUNC_LSB +: FUNC_W];
        ctl_o.dev  <= wdata_i[DEV_LSB +: DEV_W];
      end
      if (launch) begin
        busy_o <= 1'b1;
        done_o <= 1'b0;
        err_o  <= 1'b0;
      end else if (finish) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
        err_o  <= ack_err_i;
      end
      // agent data wins over a same-cycle software write
      if (finish && !ctl_o.wr) rtn_o <= ack_data_i;
      else if (rtn_we_i)       rtn_o <= wdata_i;
    end
  end

  // R5
  pulse_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
  // R5
  pulse_with_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> busy_o);
  // R6
  launch_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> busy_o && !done_o && !err_o);
  // R7
  ack_completes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish |=> !busy_o && done_o && (err_o == $past(ack_err_i)));
  // R9
  fields_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !ack_i |=> $stable(ctl_o));
endmodule

// File: rtl/cfg_req_ctrl.sv
module cfg_req_ctrl
  import cfg_req_pkg::*;
#(
  parameter logic [7:0] IMPL_ID  = 8'h41,
  parameter logic [3:0] VARIANT  = 4'h1,
  parameter logic [3:0] ARCH_ID  = 4'h4,
  parameter logic [7:0] PART_NUM = 8'hA5,
  parameter logic [3:0] REVISION = 4'h2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              req_o,
  output logic              req_write_o,
  output logic [FUNC_W-1:0] req_func_o,
  output logic [DEV_W-1:0]  req_dev_o,
  output logic [DATA_W-1:0] req_data_o,
  output logic              start_pulse_o,
  input  logic              ack_i,
  input  logic              ack_err_i,
  input  logic [DATA_W-1:0] ack_data_i,
  output logic [LED_W-1:0]  led_o,
  input  logic [SW_W-1:0]   sw_i,
  input  logic [REV_W-1:0]  board_rev_i
);
  localparam logic [DATA_W-1:0] ID_WORD =
    {IMPL_ID, VARIANT, ARCH_ID, 4'h0, PART_NUM, REVISION};

  reg_sel_e          sel;
  logic              wr_en, busy, done, err;
  ctl_t              ctl;
  logic [DATA_W-1:0] rtn;

  assign wr_en = bus_sel_i && bus_we_i;

  cfg_reg_decode u_dec (
    .addr_i (bus_addr_i),
    .sel_o  (sel)
  );

  cfg_plain_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .led_we_i (wr_en && sel == SEL_LED),
    .out_we_i (wr_en && sel == SEL_OUT),
    .wdata_i  (bus_wdata_i),
    .led_o    (led_o),
    .out_o    (req_data_o)
  );

  cfg_txn_engine u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_we_i   (wr_en && sel == SEL_CTL),
    .rtn_we_i   (wr_en && sel == SEL_RTN),
    .wdata_i    (bus_wdata_i),
    .ack_i      (ack_i),
    .ack_err_i  (ack_err_i),
    .ack_data_i (ack_data_i),
    .busy_o     (busy),
    .done_o     (done),
    .err_o      (err),
    .pulse_o    (start_pulse_o),
    .ctl_o      (ctl),
    .rtn_o      (rtn)
  );

  assign req_o       = busy;
  assign req_write_o = ctl.wr;
  assign req_func_o  = ctl.func;
  assign req_dev_o   = ctl.dev;

  always_comb begin
    bus_rdata_o = '0;
    unique case (sel)
      SEL_LED:  bus_rdata_o[LED_W-1:0] = led_o;
      SEL_SW:   bus_rdata_o[SW_W-1:0]  = sw_i;
      SEL_REV:  bus_rdata_o[REV_W-1:0] = board_rev_i;
      SEL_RTN:  bus_rdata_o = rtn;
      SEL_OUT:  bus_rdata_o = req_data_o;
      SEL_CTL:  bus_rdata_o = {busy, ctl.wr, 4'h0, ctl.func, 8'h0, ctl.dev};
      SEL_STAT: bus_rdata_o[1:0] = {err, done};
      SEL_ID:   bus_rdata_o = ID_WORD;
      default:  bus_rdata_o = '0;
    endcase
  end

  // R10
  led_follows_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en && sel == SEL_LED) |=> $stable(led_o));
endmodule

// File: tb/cfg_req_ctrl_test.sv
module cfg_req_ctrl_test;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        bsel = 0, bwe = 0, ack = 0, ack_err = 0;
  logic [11:0] baddr = '0;
  logic [31:0] bwdata = '0, ack_data = '0, rdata, req_data;
  logic        req, req_wr, pulse;
  logic [5:0]  func;
  logic [11:0] dev;
  logic [7:0]  led, sw = 8'h3C;
  logic [3:0]  rev = 4'h9;

  int errors = 0, checks = 0;
  bit done_flag = 0;

  // reference state
  bit         m_busy, m_comp, m_err, m_pulse, m_wr;
  bit [5:0]   m_func;
  bit [11:0]  m_dev;
  bit [31:0]  m_rtn, m_out;
  bit [7:0]   m_led;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_req_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_sel_i(bsel), .bus_we_i(bwe),
    .bus_addr_i(baddr), .bus_wdata_i(bwdata), .bus_rdata_o(rdata),
    .req_o(req), .req_write_o(req_wr), .req_func_o(func), .req_dev_o(dev),
    .req_data_o(req_data), .start_pulse_o(pulse), .ack_i(ack),
    .ack_err_i(ack_err), .ack_data_i(ack_data), .led_o(led), .sw_i(sw),
    .board_rev_i(rev)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    case (a[11:2])
      10'd1:    return {24'h0, m_led};
      10'd3:    return {24'h0, sw};
      10'd4:    return {28'h0, rev};
      10'd40:   return m_rtn;
      10'd41:   return m_out;
      10'd42:   return {m_busy, m_wr, 4'h0, m_func, 8'h0, m_dev};
      10'd43:   return {30'h0, m_err, m_comp};
      10'd1023: return 32'h4114_0A52;
      default:  return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [11:0] a);
    case (a[11:2])
      10'd1, 10'd3, 10'd4: return "R10 read";
      10'd40:   return "R8 return reg";
      10'd41:   return "R3 outgoing reg";
      10'd42:   return "R4 control reg";
      10'd43:   return "R6 status reg";
      default:  return "R11 id/unmapped";
    endcase
  endfunction

  task automatic model_step();
    bit w = bsel && bwe;
    bit [9:0] wd = baddr[11:2];
    bit lau = w && wd == 10'd42 && !m_busy && bwdata[31];
    bit fin = m_busy && ack;
    if (fin && !m_wr) m_rtn = ack_data;
    else if (w && wd == 10'd40) m_rtn = bwdata;
    if (w && wd == 10'd41) m_out = bwdata;
    if (w && wd == 10'd1) m_led = bwdata[7:0];
    if (w && wd == 10'd42 && !m_busy) begin
      m_wr = bwdata[30]; m_func = bwdata[25:20]; m_dev = bwdata[11:0];
    end
    m_pulse = lau;
    if (lau) begin m_busy = 1; m_comp = 0; m_err = 0; end
    else if (fin) begin m_busy = 0; m_comp = 1; m_err = ack_err; end
  endtask

  task automatic compare_all();
    chk("R7 req_o", {31'h0, req}, {31'h0, m_busy});
    chk("R5 start pulse", {31'h0, pulse}, {31'h0, m_pulse});
    chk("R10 led_o", {24'h0, led}, {24'h0, m_led});
    chk("R3 req_data_o", req_data, m_out);
    chk("R9 req fields", {13'h0, req_wr, func, dev}, {13'h0, m_wr, m_func, m_dev});
    chk(rd_tag(baddr), rdata, exp_rd(baddr));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bsel = 1; bwe = 1; baddr = a; bwdata = d;
    cyc();
    bsel = 0; bwe = 0;
  endtask

  task automatic rd(input logic [11:0] a);
    bsel = 1; bwe = 0; baddr = a;
    cyc();
    bsel = 0;
  endtask

  task automatic do_ack(input logic e, input logic [31:0] d);
    ack = 1; ack_err = e; ack_data = d;
    cyc();
    ack = 0; ack_err = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done_flag) begin
      errors++;
      $display("FAIL R7 watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    baddr = 12'h0A8;
    #1;
    // R1 reset state
    chk("R1 req_o", {31'h0, req}, 32'h0);
    chk("R1 pulse", {31'h0, pulse}, 32'h0);
    chk("R1 led_o", {24'h0, led}, 32'h0);
    chk("R1 control read", rdata, 32'h0);
    rst_ni = 1;
    cyc();
    // R10 LED, switches, revision
    wr(12'h004, 32'hFFFF_FF5A);
    rd(12'h004); rd(12'h00C); rd(12'h010);
    // R2 low address bits ignored
    wr(12'h0A7, 32'h1357_9BDF);
    rd(12'h0A4); rd(12'h0A6);
    wr(12'h0A1, 32'h2468_ACE0);
    rd(12'h0A0);
    // R4 field write without start
    wr(12'h0A8, 32'h4FF0_0ABC);
    rd(12'h0AB);
    // R5 launch read request
    wr(12'h0A8, 32'h8050_0003);
    rd(12'h0A8); rd(12'h0AC);
    // R9 control writes ignored while busy
    wr(12'h0A8, 32'h40FF_FFFF);
    wr(12'h0A8, 32'hC000_0FFF);
    rd(12'h0A8);
    // R7 R8 ack of read request
    do_ack(1'b0, 32'hCAFE_F00D);
    rd(12'h0A0); rd(12'h0AC);
    // R6 status writes ignored
    wr(12'h0AC, 32'hFFFF_FFFF);
    rd(12'h0AC);
    // R8 write request with error: return reg kept
    wr(12'h0A8, 32'hC010_0007);
    cyc();
    do_ack(1'b1, 32'h0000_1234);
    rd(12'h0A0); rd(12'h0AC);
    // R6 relaunch clears status
    wr(12'h0A8, 32'h8020_0001);
    rd(12'h0AC);
    // R8 software write and agent data in same cycle
    bsel = 1; bwe = 1; baddr = 12'h0A0; bwdata = 32'h5555_AAAA;
    ack = 1; ack_data = 32'h0BAD_BEEF;
    cyc();
    bsel = 0; bwe = 0; ack = 0;
    rd(12'h0A0);
    // R9 ack while idle ignored
    do_ack(1'b1, 32'hDEAD_0000);
    rd(12'h0AC); rd(12'h0A0);
    // R5 back-to-back launches
    for (int i = 0; i < 4; i++) begin
      wr(12'h0A8, {1'b1, i[0], 4'h0, 6'(i + 1), 8'h0, 12'(i * 17)});
      do_ack(i[1], 32'h100 + 32'(i));
      rd(12'h0A8);
    end
    // R11 identification and unmapped
    rd(12'hFFC); rd(12'hFFF); rd(12'h100); rd(12'h008);
    sw = 8'hC3; rev = 4'h6;
    rd(12'h00C); rd(12'h010);
    repeat (3) cyc();
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule